// File: doc/BRIEF.md
# Two-Phase Command Frame Encoder

This block sits on the controller side of a low-power DRAM link. It takes one high-level request at a time and drives it onto a 6-bit single-data-rate command/address bus. The supported requests are row activate, read, write, masked write, precharge, refresh, mode register write and mode register read. Every command on the bus is a two-cycle frame. The chip select line is high in the first cycle of the frame and low in the second. Requests that carry an address are split into two back-to-back commands, so they occupy four cycles.

Requests come in over a ready/valid handshake. The cycle after a request is accepted, the encoder drives the first frame cycle. It holds `busy` high and `req_ready` low until the last frame cycle has been driven. When no frame is in progress, the bus carries the all-zero no-operation pattern. The burst length bit can be fixed at 16 or 32 by a parameter, or taken from each request. Bank state, DRAM timing and the data path belong to other blocks.

Top module: `cmd_frame_enc`

## Requirements
- R1: After reset, `ca_cs` is 0, `ca` is 6'b000000, `busy` is 0 and `req_ready` is 1.
- R2: Every command takes exactly two cycles, with `ca_cs` at 1 in the first cycle and 0 in the second. `ca_cs` is never 1 in two consecutive cycles.
- R3: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1, and its first frame cycle appears in the cycle right after that edge. `busy`=1 and `req_ready`=0 hold through all frame cycles, and inputs that change during a frame do not affect it. After the last frame cycle, one idle cycle with `req_ready`=1 always follows.
- R4: Activate (`req_op`=0) sends two commands. The first is {row[15],row[14],row[13],row[12],0,1} then {row[11],row[10],row[16],bank[2:0]}. The second is {row[9:6],1,1} then row[5:0]. Words are written as ca[5:0].
- R5: Read (`req_op`=1), write (2) and masked write (3) send a first command and then a CAS-2 command. The first word is {BL,00010} for read, {BL,00100} for write and {0,01100} for masked write. The second word of the first command is {AP,col[9],0,bank[2:0]}. CAS-2 is {col[8],10010} then col[7:2].
- R6: Precharge (`req_op`=4) sends one command: {all,10000} then {000,bank[2:0]}. Refresh (`req_op`=5) also sends one command: {all,01000} then {000,bank[2:0]}. Here `all`=1 selects every bank. Both occupy only two cycles.
- R7: Mode register write (`req_op`=6) sends {opd[7],00110}, ma[5:0], {opd[6],10110}, opd[5:0]. Mode register read (`req_op`=7) sends {0,01110}, ma[5:0], then a CAS-2 command with a zero column, {0,10010} and 000000.
- R8: The BL bit is 0 for a burst of 16 and 1 for a burst of 32. With BURST_MODE 0 it is always 0, with 1 it is always 1, and with 2 (the default) it follows `req_bl`.
- R9: Column bits col[1:0] are never sent. Changing them leaves every bus word unchanged.
- R10: When `busy` is 0, the bus carries the no-operation pattern: `ca_cs`=0 and `ca`=000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Encoder idle and able to accept |
| req_op | input | 3 | Request kind, 0..7 as in R4 to R7 |
| req_bank | input | 3 | Bank address |
| req_row | input | 17 | Row address |
| req_col | input | 10 | Column address; bits 1:0 ignored |
| req_bl | input | 1 | Per-access burst select (1 = 32) |
| req_ap | input | 1 | Auto-precharge for read/write |
| req_all | input | 1 | All-bank select for precharge/refresh |
| req_ma | input | 6 | Mode register address |
| req_opd | input | 8 | Mode register write data |
| busy | output | 1 | A frame sequence is being driven |
| ca_cs | output | 1 | Chip select, high in first frame cycle |
| ca | output | 6 | Command/address bus |

## Verification
The accepting edge is the edge where `req_valid` is high while `req_ready` reads high at the preceding falling edge. The bench samples at falling edges, so the k-th frame word (k from 0) is checked at the (k+1)-th falling edge after that edge. The next falling edge after the final word must show the idle pattern with `req_ready` high. During a frame the bench keeps `req_valid` high and scrambles the request fields, which shows that nothing is accepted and nothing changes mid-frame. It drops `req_valid` at the falling edge of the last frame cycle. A second instance with a fixed burst of 32 receives the same stimulus and is checked word for word in the same cycles.

// File: rtl/cfe_pkg.sv
package cfe_pkg;

   localparam int CMD_W = 6;

   typedef logic [CMD_W-1:0] caw_t;

   typedef enum logic [2:0] {
      OP_ACT = 3'd0,
      OP_RD  = 3'd1,
      OP_WR  = 3'd2,
      OP_MWR = 3'd3,
      OP_PRE = 3'd4,
      OP_REF = 3'd5,
      OP_MRW = 3'd6,
      OP_MRR = 3'd7
   } op_e;

   // low five bits of first-cycle words; bit 5 carries a per-command flag
   localparam logic [4:0] K_RD   = 5'b00010;
   localparam logic [4:0] K_WR   = 5'b00100;
   localparam logic [4:0] K_MWR  = 5'b01100;
   localparam logic [4:0] K_CAS  = 5'b10010;
   localparam logic [4:0] K_PRE  = 5'b10000;
   localparam logic [4:0] K_REF  = 5'b01000;
   localparam logic [4:0] K_MRW1 = 5'b00110;
   localparam logic [4:0] K_MRW2 = 5'b10110;
   localparam logic [4:0] K_MRR  = 5'b01110;

   function automatic logic needs_two(input op_e op);
      return !(op == OP_PRE || op == OP_REF);
   endfunction

endpackage

// File: rtl/cfe_bl_sel.sv
module cfe_bl_sel #(
   parameter int BURST_MODE = 2
) (
   input  logic req_bl,
   output logic bl_bit
);
   generate
      if (BURST_MODE == 0) begin : g_fix16
         logic unused_bl;
         assign unused_bl = req_bl;
         assign bl_bit    = 1'b0;
      end else if (BURST_MODE == 1) begin : g_fix32
         logic unused_bl;
         assign unused_bl = req_bl;
         assign bl_bit    = 1'b1;
      end else begin : g_dyn
         assign bl_bit = req_bl;
      end
   endgenerate
endmodule

// File: rtl/cfe_word_build.sv
module cfe_word_build
   import cfe_pkg::*;
#(
   parameter int ROW_W  = 17,
   parameter int BANK_W = 3,
   parameter int COL_W  = 10,
   parameter int MA_W   = 6,
   parameter int OPD_W  = 8,
   parameter int SLOTS  = 4
) (
   input  logic [2:0]          op,
   input  logic [BANK_W-1:0]   bank,
   input  logic [ROW_W-1:0]    row,
   input  logic [COL_W-1:0]    col,
   input  logic                bl,
   input  logic                ap,
   input  logic                all,
   input  logic [MA_W-1:0]     ma,
   input  logic [OPD_W-1:0]    opd,
   output logic [SLOTS-1:0][CMD_W-1:0] words,
   output logic                two_cmd
);
   localparam int PAD_W = CMD_W - BANK_W;

   logic unused_col_lo;
   assign unused_col_lo = ^col[1:0];

   caw_t bank_word;
   caw_t cas_a, cas_b;
   assign bank_word = {{PAD_W{1'b0}}, bank};
   assign cas_a     = {col[8], K_CAS};
   assign cas_b     = col[7:2];

   always_comb begin
      words   = '0;
      two_cmd = needs_two(op_e'(op));
      case (op_e'(op))
         OP_ACT: begin
            words[0] = {row[15], row[14], row[13], row[12], 1'b0, 1'b1};
            words[1] = {row[11], row[10], row[16], bank};
            words[2] = {row[9:6], 1'b1, 1'b1};
            words[3] = row[5:0];
         end
         OP_RD: begin
            words[0] = {bl, K_RD};
            words[1] = {ap, col[9], 1'b0, bank};
            words[2] = cas_a;
            words[3] = cas_b;
         end
         OP_WR: begin
            words[0] = {bl, K_WR};
            words[1] = {ap, col[9], 1'b0, bank};
            words[2] = cas_a;
            words[3] = cas_b;
         end
         OP_MWR: begin
            words[0] = {1'b0, K_MWR};
            words[1] = {ap, col[9], 1'b0, bank};
            words[2] = cas_a;
            words[3] = cas_b;
         end
         OP_PRE: begin
            words[0] = {all, K_PRE};
            words[1] = bank_word;
         end
         OP_REF: begin
            words[0] = {all, K_REF};
            words[1] = bank_word;
         end
         OP_MRW: begin
            words[0] = {opd[7], K_MRW1};
            words[1] = ma;
            words[2] = {opd[6], K_MRW2};
            words[3] = opd[5:0];
         end
         OP_MRR: begin
            words[0] = {1'b0, K_MRR};
            words[1] = ma;
            words[2] = {1'b0, K_CAS};
            words[3] = '0;
         end
         default: words = '0;
      endcase
   end
endmodule

// File: rtl/cfe_frame_seq.sv
module cfe_frame_seq
   import cfe_pkg::*;
#(
   parameter int SLOTS = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load,
   input  logic [SLOTS-1:0][CMD_W-1:0] words,
   input  logic                       two_cmd,
   output logic                       active,
   output logic                       cs_q,
   output logic [CMD_W-1:0]           ca_q
);
   localparam int IDX_W = $clog2(SLOTS);
   localparam logic [IDX_W-1:0] LAST_ONE = IDX_W'(1);
   localparam logic [IDX_W-1:0] LAST_TWO = IDX_W'(SLOTS - 1);

   logic [SLOTS-1:0][CMD_W-1:0] wq;
   logic [IDX_W-1:0]            cur;
   logic [IDX_W-1:0]            last;
   logic [IDX_W-1:0]            nxt;

   assign nxt = cur + IDX_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         cs_q   <= 1'b0;
         ca_q   <= '0;
         wq     <= '0;
         cur    <= '0;
         last   <= '0;
      end else if (load) begin
         active <= 1'b1;
         wq     <= words;
         last   <= two_cmd ? LAST_TWO : LAST_ONE;
         cur    <= '0;
         cs_q   <= 1'b1;
         ca_q   <= words[0];
      end else if (active) begin
         if (cur == last) begin
            active <= 1'b0;
            cs_q   <= 1'b0;
            ca_q   <= '0;
         end else begin
            cur  <= nxt;
            cs_q <= cur[0];
            ca_q <= wq[nxt];
         end
      end
   end
endmodule

// File: rtl/cmd_frame_enc.sv
module cmd_frame_enc
   import cfe_pkg::*;
#(
   parameter int CA_W       = 6,
   parameter int ROW_W      = 17,
   parameter int BANK_W     = 3,
   parameter int COL_W      = 10,
   parameter int MA_W       = 6,
   parameter int OPD_W      = 8,
   parameter int BURST_MODE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_op,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic              req_bl,
   input  logic              req_ap,
   input  logic              req_all,
   input  logic [MA_W-1:0]   req_ma,
   input  logic [OPD_W-1:0]  req_opd,
   output logic              busy,
   output logic              ca_cs,
   output logic [CA_W-1:0]   ca
);
   localparam int SLOTS = 4;

   generate
      if (CA_W != CMD_W) begin : g_bad_ca
         $error("cmd_frame_enc: CA_W must be 6");
      end
      if (ROW_W != 17 || BANK_W != 3 || COL_W != 10) begin : g_bad_addr
         $error("cmd_frame_enc: address widths must be 17/3/10");
      end
      if (MA_W != 6 || OPD_W != 8) begin : g_bad_mr
         $error("cmd_frame_enc: mode register widths must be 6/8");
      end
      if (BURST_MODE < 0 || BURST_MODE > 2) begin : g_bad_bl
         $error("cmd_frame_enc: BURST_MODE must be 0, 1 or 2");
      end
   endgenerate

   logic                        bl_bit;
   logic [SLOTS-1:0][CMD_W-1:0] words;
   logic                        two_cmd;
   logic                        active;
   logic                        load;

   assign req_ready = !active;
   assign load      = req_valid && !active;
   assign busy      = active;

   cfe_bl_sel #(.BURST_MODE(BURST_MODE)) u_bl (
      .req_bl (req_bl),
      .bl_bit (bl_bit)
   );

   cfe_word_build #(
      .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W),
      .MA_W(MA_W), .OPD_W(OPD_W), .SLOTS(SLOTS)
   ) u_build (
      .op      (req_op),
      .bank    (req_bank),
      .row     (req_row),
      .col     (req_col),
      .bl      (bl_bit),
      .ap      (req_ap),
      .all     (req_all),
      .ma      (req_ma),
      .opd     (req_opd),
      .words   (words),
      .two_cmd (two_cmd)
   );

   cfe_frame_seq #(.SLOTS(SLOTS)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .words   (words),
      .two_cmd (two_cmd),
      .active  (active),
      .cs_q    (ca_cs),
      .ca_q    (ca)
   );
endmodule

// File: rtl/cfe_chk.sv
module cfe_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic       busy,
   input logic       ca_cs,
   input logic [5:0] ca
);
   // R2
   cs_two_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ca_cs |=> !ca_cs);

   // R10
   idle_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ca_cs && ca == 6'b000000));

   // R3
   accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (ca_cs && busy));

   // R5
   cas_after_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ca_cs && (ca[4:0] == 5'b00010 || ca[4:0] == 5'b00100 || ca[4:0] == 5'b01100))
      |-> ##2 (ca_cs && ca[4:0] == 5'b10010));

   // R6
   single_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ca_cs && ca[4:0] == 5'b10000) |-> ##2 !busy);
endmodule

bind cmd_frame_enc cfe_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .busy      (busy),
   .ca_cs     (ca_cs),
   .ca        (ca)
);

// File: tb/cmd_frame_enc_bench.sv
module cmd_frame_enc_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_op = '0;
   logic [2:0]  req_bank = '0;
   logic [16:0] req_row = '0;
   logic [9:0]  req_col = '0;
   logic        req_bl = 1'b0;
   logic        req_ap = 1'b0;
   logic        req_all = 1'b0;
   logic [5:0]  req_ma = '0;
   logic [7:0]  req_opd = '0;

   logic       rdy, bsy, cs;
   logic [5:0] ca;
   logic       rdy_f, bsy_f, cs_f;
   logic [5:0] ca_f;

   int vectors = 0;
   int misses  = 0;
   int cycles  = 0;

   always #2.5 clk = ~clk;

   cmd_frame_enc u_cmd_frame_enc (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy),
      .req_op(req_op), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
      .req_bl(req_bl), .req_ap(req_ap), .req_all(req_all), .req_ma(req_ma),
      .req_opd(req_opd), .busy(bsy), .ca_cs(cs), .ca(ca)
   );

   cmd_frame_enc #(.BURST_MODE(1)) u_cmd_frame_enc_fix32 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_f),
      .req_op(req_op), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
      .req_bl(req_bl), .req_ap(req_ap), .req_all(req_all), .req_ma(req_ma),
      .req_opd(req_opd), .busy(bsy_f), .ca_cs(cs_f), .ca(ca_f)
   );

   function automatic int frame_len(input logic [2:0] op);
      return (op == 3'd4 || op == 3'd5) ? 2 : 4;
   endfunction

   // expected words per R4..R8; w0 in bits 5:0
   function automatic logic [23:0] model(input logic [2:0] op, input logic [2:0] bk,
         input logic [16:0] r, input logic [9:0] c, input logic bl, input logic ap,
         input logic al, input logic [5:0] m, input logic [7:0] d);
      logic [5:0] w0, w1, w2, w3;
      w0 = 0; w1 = 0; w2 = 0; w3 = 0;
      case (op)
         3'd0: begin w0 = {r[15], r[14], r[13], r[12], 2'b01};
                     w1 = {r[11], r[10], r[16], bk};
                     w2 = {r[9:6], 2'b11}; w3 = r[5:0]; end
         3'd1, 3'd2, 3'd3: begin
            w0 = (op == 3'd1) ? {bl, 5'b00010} : (op == 3'd2) ? {bl, 5'b00100} : 6'b001100;
            w1 = {ap, c[9], 1'b0, bk};
            w2 = {c[8], 5'b10010}; w3 = c[7:2]; end
         3'd4: begin w0 = {al, 5'b10000}; w1 = {3'b000, bk}; end
         3'd5: begin w0 = {al, 5'b01000}; w1 = {3'b000, bk}; end
         3'd6: begin w0 = {d[7], 5'b00110}; w1 = m; w2 = {d[6], 5'b10110}; w3 = d[5:0]; end
         default: begin w0 = 6'b001110; w1 = m; w2 = 6'b010010; w3 = 6'b000000; end
      endcase
      return {w3, w2, w1, w0};
   endfunction

   task automatic check(input logic ok, input string tag, input logic [8:0] act, input logic [8:0] exp);
      vectors++;
      if (!ok) begin
         misses++;
         $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic scramble();
      req_op   = 3'($urandom);  req_bank = 3'($urandom);
      req_row  = 17'($urandom); req_col  = 10'($urandom);
      req_bl   = 1'($urandom);  req_ap   = 1'($urandom);
      req_all  = 1'($urandom);  req_ma   = 6'($urandom);
      req_opd  = 8'($urandom);
   endtask

   task automatic send(input logic [2:0] op, input logic [2:0] bk, input logic [16:0] r,
         input logic [9:0] c, input logic bl, input logic ap, input logic al,
         input logic [5:0] m, input logic [7:0] d, input string tag);
      logic [23:0] e, e32;
      int n;
      e   = model(op, bk, r, c, bl, ap, al, m, d);
      e32 = model(op, bk, r, c, 1'b1, ap, al, m, d);
      n   = frame_len(op);
      @(negedge clk);
      // R10 idle NOP and R3 ready before each request
      check(rdy && !bsy && !cs && ca == 6'd0, "R10/R3 idle",
            {rdy, bsy, cs, ca}, {1'b1, 1'b0, 1'b0, 6'd0});
      req_op = op; req_bank = bk; req_row = r; req_col = c; req_bl = bl;
      req_ap = ap; req_all = al; req_ma = m; req_opd = d; req_valid = 1'b1;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         // R2 phase, R3 busy/ready, and the tagged encoding
         check(cs == (k % 2 == 0) && ca == e[k*6 +: 6] && bsy && !rdy, tag,
               {rdy, bsy, cs, ca}, {1'b0, 1'b1, 1'(k % 2 == 0), e[k*6 +: 6]});
         // R8 fixed-32 instance
         check(cs_f == (k % 2 == 0) && ca_f == e32[k*6 +: 6] && bsy_f, "R8 fix32",
               {rdy_f, bsy_f, cs_f, ca_f}, {1'b0, 1'b1, 1'(k % 2 == 0), e32[k*6 +: 6]});
         scramble();
         if (k == n - 1) req_valid = 1'b0;
      end
   endtask

   task automatic send_rand();
      logic [2:0] op;
      string tag;
      op = 3'($urandom);
      case (op)
         3'd0: tag = "R4 act";
         3'd1, 3'd2, 3'd3: tag = "R5 rd/wr";
         3'd4, 3'd5: tag = "R6 pre/ref";
         default: tag = "R7 mode reg";
      endcase
      send(op, 3'($urandom), 17'($urandom), 10'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 6'($urandom), 8'($urandom), tag);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         misses++;
         vectors++;
         $display("FAIL R3 watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0C4A));
      repeat (3) @(negedge clk);
      // R1 reset state, during reset
      check(!cs && ca == 6'd0 && !bsy && rdy, "R1 reset",
            {rdy, bsy, cs, ca}, {1'b1, 1'b0, 1'b0, 6'd0});
      rst_n = 1'b1;
      @(negedge clk);
      check(!cs && ca == 6'd0 && !bsy && rdy, "R1 after release",
            {rdy, bsy, cs, ca}, {1'b1, 1'b0, 1'b0, 6'd0});

      // directed corners
      send(3'd0, 3'b101, 17'h1_A5C3, 10'd0, 1'b0, 1'b0, 1'b0, 6'd0, 8'd0, "R4 act");
      send(3'd0, 3'b000, 17'h1_0000, 10'd0, 1'b0, 1'b0, 1'b0, 6'd0, 8'd0, "R4 act r16");
      send(3'd1, 3'b011, 17'd0, 10'h3FC, 1'b0, 1'b1, 1'b0, 6'd0, 8'd0, "R5 R8 rd bl16");
      send(3'd1, 3'b011, 17'd0, 10'h3FC, 1'b1, 1'b1, 1'b0, 6'd0, 8'd0, "R5 R8 rd bl32");
      send(3'd2, 3'b111, 17'd0, 10'h155, 1'b1, 1'b0, 1'b0, 6'd0, 8'd0, "R5 wr");
      send(3'd3, 3'b001, 17'd0, 10'h2AA, 1'b1, 1'b1, 1'b0, 6'd0, 8'd0, "R5 mwr");
      send(3'd1, 3'b010, 17'd0, 10'h244, 1'b0, 1'b0, 1'b0, 6'd0, 8'd0, "R9 col lo 00");
      send(3'd1, 3'b010, 17'd0, 10'h247, 1'b0, 1'b0, 1'b0, 6'd0, 8'd0, "R9 col lo 11");
      send(3'd4, 3'b110, 17'd0, 10'd0, 1'b0, 1'b0, 1'b1, 6'd0, 8'd0, "R6 pre all");
      send(3'd4, 3'b110, 17'd0, 10'd0, 1'b0, 1'b0, 1'b0, 6'd0, 8'd0, "R6 pre one");
      send(3'd5, 3'b100, 17'd0, 10'd0, 1'b0, 1'b0, 1'b1, 6'd0, 8'd0, "R6 ref all");
      send(3'd6, 3'b000, 17'd0, 10'd0, 1'b0, 1'b0, 1'b0, 6'h2D, 8'hC3, "R7 mrw");
      send(3'd7, 3'b000, 17'd0, 10'd0, 1'b0, 1'b0, 1'b0, 6'h3F, 8'd0, "R7 mrr");

      for (int i = 0; i < 400; i++) send_rand();

      @(negedge clk);
      check(rdy && !bsy && !cs && ca == 6'd0, "R10 final idle",
            {rdy, bsy, cs, ca}, {1'b1, 1'b0, 1'b0, 6'd0});
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule